// File: doc/BRIEF.md
# Dual-Format SPI Clock Prescaler

This block turns a fast core clock into a serial clock for an SPI host. A software-written prescale field sets the ratio between the core clock and the serial clock. The field can use one of two encodings, and an elaboration parameter picks which one. The compact encoding gives even divisors from 4 to 30. The wide encoding combines a 4-bit mantissa with a 3-bit power-of-two exponent and reaches a divisor of 1920.

While enabled, the block drives the serial clock away from its idle level for the first half of each period and back to idle for the second half. Alongside the clock it gives one-cycle strobes marking each rising and each falling edge, which the shifter logic uses to launch and capture data. While disabled, the clock rests at the idle polarity. A change of field or polarity while running waits for the end of the current period, so no period is ever cut short or stretched.

Top module: `sck_prescaler`

## Requirements
- R1: While rst_ni is low, sck_o, rise_o and fall_o are all 0.
- R2: While en_i is sampled low, sck_o follows cpol_i with one cycle of delay, and no clock edges are generated from the counter.
- R3: With EXT_FMT=0, the divisor is twice cfg_i[3:0]. Bits cfg_i[7:4] have no effect.
- R4: With EXT_FMT=0, a computed divisor below 4 is raised to 4.
- R5: With EXT_FMT=1, the divisor is M shifted left by E. M is cfg_i[3:0]. E is {cfg_i[7], cfg_i[6], cfg_i[4]}, with cfg_i[4] as the least significant bit. cfg_i[5] has no effect. The largest divisor is 15·128 = 1920.
- R6: With EXT_FMT=1, a mantissa of 0 or 1 is used as 2, and a resulting divisor below 4 is raised to 4.
- R7: Take the first clock edge that samples en_i high after idle. In the next cycle, sck_o leaves the idle level. For a divisor D, sck_o stays at the non-idle level for ceil(D/2) cycles and then at the idle level for floor(D/2) cycles, and this repeats.
- R8: rise_o is 1 exactly in the cycles where sck_o is 1 and was 0 in the previous cycle. fall_o is 1 exactly in the cycles where sck_o is 0 and was 1 in the previous cycle.
- R9: While running, cfg_i and cpol_i are sampled only at the start edge and at each period boundary. A change in mid-period applies from the next period.
- R10: A clock edge that samples en_i low returns sck_o to the cpol_i level in the following cycle, and restarts the period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for the serial clock |
| cpol_i | input | 1 | Idle level of the serial clock |
| cfg_i | input | 8 | Prescale field, decoded according to EXT_FMT |
| sck_o | output | 1 | Serial clock, registered |
| rise_o | output | 1 | One-cycle strobe on a rising edge of sck_o |
| fall_o | output | 1 | One-cycle strobe on a falling edge of sck_o |

## Verification
sck_o is a flop output, so it shows the effect of any input one cycle after the edge that samples that input. The strobes are valid in the same cycle that sck_o changes. The bench drives inputs and samples outputs on the falling edge, and it numbers the samples from the edge that first sees en_i high. The sample at index k is compared with the level that the divisor and polarity rules give for cycle k. Each sample uses the old period for the first D cycles and the new settings after that. Disable and idle checks are taken one falling edge after the change, and again one edge later to confirm that no edge strobe is left over.

// File: rtl/sck_pkg.sv
package sck_pkg;
  localparam int unsigned SCK_MIN_DIV = 4;
  localparam int unsigned SCK_MAX_DIV = 1920;
  localparam int unsigned FIELD_W     = 8;

  // wide encoding: exponent bits split around one unused bit
  typedef struct packed {
    logic [1:0] exp_hi;
    logic       rsvd;
    logic       exp_lo;
    logic [3:0] mant;
  } ext_field_t;
endpackage

// File: rtl/sck_div_decode.sv
module sck_div_decode
  import sck_pkg::*;
#(
  parameter bit          EXT_FMT = 1'b1,
  parameter int unsigned DIV_W   = 11
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DIV_W-1:0]   div_o
);
  localparam logic [DIV_W-1:0] MinDiv = DIV_W'(SCK_MIN_DIV);

  logic [DIV_W-1:0] raw;

  generate
    if (EXT_FMT) begin : g_ext
      ext_field_t f;
      logic [3:0] mant;
      logic [2:0] expo;
      logic       unused_rsvd;
      always_comb begin
        f    = ext_field_t'(field_i);
        mant = (f.mant < 4'd2) ? 4'd2 : f.mant;
        expo = {f.exp_hi, f.exp_lo};
        raw  = DIV_W'(mant) << expo;
      end
      assign unused_rsvd = f.rsvd;
    end else begin : g_leg
      logic unused_hi;
      assign raw       = DIV_W'({field_i[3:0], 1'b0});
      assign unused_hi = ^field_i[FIELD_W-1:4];
    end
  endgenerate

  assign div_o = (raw < MinDiv) ? MinDiv : raw;
endmodule

// File: rtl/sck_phase_gen.sv
module sck_phase_gen
  import sck_pkg::*;
#(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lvl_o
);
  localparam logic [DIV_W-1:0] MinDiv = DIV_W'(SCK_MIN_DIV);
  localparam logic [DIV_W-1:0] One    = DIV_W'(1);

  logic             run_q, run_n, lead_q, lead_n, pol_q, pol_n, load;
  logic [DIV_W-1:0] cnt_q, cnt_n, div_q, div_n, hi_last, lo_last;

  // leading half takes the extra cycle of an odd divisor
  assign hi_last = ({1'b0, div_q[DIV_W-1:1]} + DIV_W'(div_q[0])) - One;
  assign lo_last = {1'b0, div_q[DIV_W-1:1]} - One;

  always_comb begin
    run_n  = run_q;
    lead_n = lead_q;
    cnt_n  = cnt_q;
    load   = 1'b0;
    if (!en_i) begin
      run_n  = 1'b0;
      lead_n = 1'b0;
      cnt_n  = '0;
      load   = 1'b1;
    end else if (!run_q) begin
      run_n  = 1'b1;
      lead_n = 1'b1;
      cnt_n  = '0;
      load   = 1'b1;
    end else if (lead_q) begin
      if (cnt_q == hi_last) begin
        lead_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + One;
      end
    end else if (cnt_q == lo_last) begin
      lead_n = 1'b1;
      cnt_n  = '0;
      load   = 1'b1;
    end else begin
      cnt_n = cnt_q + One;
    end
    div_n = load ? div_i : div_q;
    pol_n = load ? pol_i : pol_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      lead_q <= 1'b0;
      pol_q  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= MinDiv;
      lvl_o  <= 1'b0;
    end else begin
      run_q  <= run_n;
      lead_q <= lead_n;
      pol_q  <= pol_n;
      cnt_q  <= cnt_n;
      div_q  <= div_n;
      lvl_o  <= pol_n ^ lead_n;
    end
  end
endmodule

// File: rtl/sck_edge_detect.sv
module sck_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
  import sck_pkg::*;
#(
  parameter bit          EXT_FMT = 1'b1,
  parameter int unsigned DIV_W   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               cpol_i,
  input  logic [FIELD_W-1:0] cfg_i,
  output logic               sck_o,
  output logic               rise_o,
  output logic               fall_o
);
  logic [DIV_W-1:0] div;
  logic             lvl;

  sck_div_decode #(.EXT_FMT(EXT_FMT), .DIV_W(DIV_W)) u_dec (
    .field_i (cfg_i),
    .div_o   (div)
  );

  sck_phase_gen #(.DIV_W(DIV_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .pol_i  (cpol_i),
    .div_i  (div),
    .lvl_o  (lvl)
  );

  sck_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rise_o (rise_o),
    .fall_o (fall_o)
  );

  assign sck_o = lvl;
endmodule

// File: rtl/sck_prescaler_chk.sv
module sck_prescaler_chk
  import sck_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic sck_o,
  input logic rise_o,
  input logic fall_o
);
  logic        armed, sck_last;
  logic [11:0] hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed    <= 1'b0;
      sck_last <= 1'b0;
      hold_cnt <= '0;
    end else begin
      armed    <= 1'b1;
      sck_last <= sck_o;
      if (!en_i || sck_o != sck_last) hold_cnt <= '0;
      else if (hold_cnt != 12'hfff)   hold_cnt <= hold_cnt + 12'd1;
    end
  end

  // R8
  a_r8_rise_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> sck_o);
  a_r8_fall_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !sck_o);
  a_r8_rose_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $rose(sck_o)) |-> rise_o);
  // R2, R10
  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(en_i)) |-> (sck_o == $past(cpol_i)));
  // R7: each half period lasts at least two core cycles
  a_r7_min_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && rise_o && en_i && $past(en_i)) |=> !fall_o);
  a_r7_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && fall_o && en_i && $past(en_i)) |=> !rise_o);
  a_r7_keeps_toggling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cnt < 12'(SCK_MAX_DIV));
endmodule

bind sck_prescaler sck_prescaler_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .cpol_i (cpol_i),
  .sck_o  (sck_o),
  .rise_o (rise_o),
  .fall_o (fall_o)
);

// File: tb/sim_sck_prescaler.sv
`timescale 1ns/1ps
module sim_sck_prescaler;
  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, cpol = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic [1:0] sck_w, rise_w, fall_w;
  int         n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  // u0: wide encoding, u1: compact encoding
  sck_prescaler #(.EXT_FMT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cfg_i(cfg),
    .sck_o(sck_w[0]), .rise_o(rise_w[0]), .fall_o(fall_w[0]));
  sck_prescaler #(.EXT_FMT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cfg_i(cfg),
    .sck_o(sck_w[1]), .rise_o(rise_w[1]), .fall_o(fall_w[1]));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic int exp_div(input bit ext, input logic [7:0] c);
    int d, s;
    if (ext) begin
      s = int'(c[3:0]);
      if (s < 2) s = 2;
      d = s << {c[7:6], c[4]};
    end else begin
      d = 2 * int'(c[3:0]);
    end
    if (d < 4) d = 4;
    return d;
  endfunction

  function automatic bit exp_lvl(input int k, input int da, input int db,
                                 input bit pa, input bit pb);
    int j;
    if (k <= 0) return pa;
    if (k <= da) return pa ^ ((k - 1) < (da + 1) / 2);
    j = (k - da - 1) % db;
    return pb ^ (j < (db + 1) / 2);
  endfunction

  task automatic run_case(input logic [7:0] ca, input bit pa,
                          input logic [7:0] cb, input bit pb, input string tag);
    int da[2], db[2], kmax;
    bit bad_s[2], bad_e[2];
    da[0] = exp_div(1'b1, ca); da[1] = exp_div(1'b0, ca);
    db[0] = exp_div(1'b1, cb); db[1] = exp_div(1'b0, cb);
    bad_s = '{0, 0}; bad_e = '{0, 0};
    @(negedge clk); en = 1'b0; cfg = ca; cpol = pa;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 2; d++)
      check(sck_w[d] == pa, "R2", "idle level before start", sck_w[d], pa);
    en = 1'b1;
    kmax = ((da[0] + db[0]) > (da[1] + db[1]) ? (da[0] + db[0]) : (da[1] + db[1])) + 1;
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        if (k <= da[d] + db[d] + 1) begin
          bit e, p;
          logic [1:0] es, as;
          e  = exp_lvl(k, da[d], db[d], pa, pb);
          p  = exp_lvl(k - 1, da[d], db[d], pa, pb);
          es = {e & ~p, ~e & p};
          as = {rise_w[d], fall_w[d]};
          if (!bad_s[d] && sck_w[d] != e) begin
            bad_s[d] = 1'b1;
            check(1'b0, {"R7 ", tag}, $sformatf("dut%0d sck at k=%0d", d, k), sck_w[d], e);
          end
          if (!bad_e[d] && as != es) begin
            bad_e[d] = 1'b1;
            check(1'b0, {"R8 ", tag}, $sformatf("dut%0d {rise,fall} at k=%0d", d, k), as, es);
          end
        end
      end
      if (k == 2) begin cfg = cb; cpol = pb; end
    end
    for (int d = 0; d < 2; d++) begin
      if (!bad_s[d]) check(1'b1, {"R7 ", tag}, "sck sequence", 0, 0);
      if (!bad_e[d]) check(1'b1, {"R8 ", tag}, "strobe sequence", 0, 0);
    end
    en = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      check(sck_w[d] == pb, "R10", "level after disable", sck_w[d], pb);
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      check(sck_w[d] == pb && !rise_w[d] && !fall_w[d], "R2 R10", "quiet while disabled",
            {rise_w[d], fall_w[d], sck_w[d]}, {2'b00, pb});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) begin
      @(negedge clk);
      cpol = 1'b1; en = 1'b1; cfg = 8'h15;
      for (int d = 0; d < 2; d++)
        check(sck_w[d] == 1'b0 && !rise_w[d] && !fall_w[d], "R1", "outputs in reset",
              {rise_w[d], fall_w[d], sck_w[d]}, 0);
    end
    @(negedge clk); en = 1'b0; cpol = 1'b0; rst_n = 1'b1;

    run_case(8'h15, 1'b0, 8'h15, 1'b0, "R3 R5");
    run_case(8'h05, 1'b0, 8'h05, 1'b0, "R5 odd");
    run_case(8'h05, 1'b1, 8'h05, 1'b1, "R5 odd idle-high");
    run_case(8'h00, 1'b0, 8'h00, 1'b0, "R4 R6 zero");
    run_case(8'h11, 1'b1, 8'h11, 1'b1, "R4 R6 one");
    run_case(8'h41, 1'b0, 8'h41, 1'b0, "R4 R6");
    run_case(8'h07, 1'b0, 8'h27, 1'b0, "R5 bit5 ignored");
    run_case(8'hE6, 1'b0, 8'hE6, 1'b0, "R3 upper bits ignored");
    run_case(8'h1F, 1'b1, 8'h1F, 1'b1, "R3 max compact");
    run_case(8'hDF, 1'b0, 8'hDF, 1'b1, "R5 max wide");
    run_case(8'h03, 1'b0, 8'h0C, 1'b1, "R9 change mid-period");
    run_case(8'h0C, 1'b1, 8'h03, 1'b0, "R9 change back");
    for (int i = 0; i < 20; i++)
      run_case(8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), "R9 random");

    summary();
    $finish;
  end
endmodule